// File: doc/BRIEF.md
# Watchdog Timer with Selectable Tick Resolution

This block is a bus-attached watchdog. Software programs a 16-bit timeout in ticks, picks one of four tick periods, sets a global enable and starts the timer. It then writes a keep-alive trigger at regular intervals. Each trigger reloads a down-counter from the programmed timeout. If software stops sending triggers and the counter reaches zero, the block pulses either a reboot request or a shutdown request, depending on a control bit. It also sets a sticky fired flag.

The fired flag is cleared only by a power-on reset, not by the ordinary system reset. Software can therefore read it after boot to learn whether the watchdog caused the last restart. A divider turns the system clock into ticks. The clock frequency is a parameter, so the four tick periods stay the same whatever the clock rate.

Register access is a single-cycle write strobe with address and data. Read data is a combinational function of the address.

Top module: `wdt_resolution_timer`

## Requirements
- R1: Power-on reset leaves every register reading 0, including the remaining count at offset 0x4, and leaves both request outputs low.
- R2: Register offsets: 0x0 is control, 0x4 is count, 0x8 is configuration. Control bits: bit 0 start, bit 1 fired, bit 2 action (0 = reboot, 1 = shutdown), bit 7 trigger. Bit 7 and bits 6:3 always read 0. Configuration bits: bit 7 global enable, bits 1:0 resolution code. All other bits read 0.
- R3: A write with control bit 7 set loads the counter only if that same write sets bit 0 and global enable is 1. Any other trigger is ignored. Setting start without a trigger does not change the remaining count.
- R4: The tick period in clock cycles is max(1, floor(CLK_HZ * P / 1e6)), where P is 32, 10000, 100000 or 1000000 µs for codes 0 to 3. The count decrements once per tick. The first decrement lands one full period after the trigger's clock edge.
- R5: When the count steps from 1 to 0, exactly one one-cycle pulse appears in the following cycle: on reboot_req if action is 0, on shutdown_req if action is 1. The count then stays at 0 with no further pulse until the next accepted trigger.
- R6: Every accepted trigger reloads the counter from the programmed timeout and restarts the tick phase, acting as a keep-alive.
- R7: Expiry sets the fired flag. Writing 1 to control bit 1 clears it and writing 0 leaves it unchanged. If expiry and a clear land in the same cycle, the flag ends up set.
- R8: The system reset `rst` clears start, action, configuration and counter, but not the fired flag. Only `por_rst` clears it.
- R9: Clearing start, or clearing global enable, freezes the remaining count and disarms the counter. No request can follow until a new accepted trigger.
- R10: A timeout write of 0 is stored as 1. Only the low 16 bits of the written value are used.
- R11: Writing a different resolution code restarts the tick phase, so the next tick comes one full new period after that write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Power-on reset, synchronous active-high; clears everything including the fired flag |
| rst | input | 1 | System reset, synchronous active-high; keeps the fired flag |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| reboot_req | output | 1 | One-cycle reboot request on expiry |
| shutdown_req | output | 1 | One-cycle shutdown request on expiry |

## Verification
The bound checker watches several properties on every cycle:
- the two requests never overlap, and each lasts one cycle;
- a request always comes with the fired flag set and the count having just stepped from 1 to 0;
- the count never rises without an accepted trigger, and sticks at 0 once there;
- the fired flag drops only on a clear write or power-on reset;
- no request follows a cycle in which the timer was not running.

The bench scenarios cover what needs exact cycle counts or register read-back: the tick period for each resolution code, the reload on keep-alive, the phase restart on a resolution change, the clamp of a zero timeout, and which reset preserves the fired flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned BUS_W     = 32;
    localparam int unsigned OFS_CTRL  = 'h0;
    localparam int unsigned OFS_COUNT = 'h4;
    localparam int unsigned OFS_CFG   = 'h8;

    localparam int unsigned CTRL_RUN_BIT   = 0;
    localparam int unsigned CTRL_FIRED_BIT = 1;
    localparam int unsigned CTRL_ACT_BIT   = 2;
    localparam int unsigned CTRL_KICK_BIT  = 7;
    localparam int unsigned CFG_EN_BIT     = 7;

    typedef enum logic [1:0] {
        RES_32US  = 2'd0,
        RES_10MS  = 2'd1,
        RES_100MS = 2'd2,
        RES_1S    = 2'd3
    } res_e;

    typedef enum logic {
        ACT_REBOOT   = 1'b0,
        ACT_SHUTDOWN = 1'b1
    } act_e;

    typedef struct packed {
        logic run_en;
        act_e action;
    } ctrl_t;

    typedef struct packed {
        logic glob_en;
        res_e res;
    } cfg_t;

    // Clock cycles per tick for a resolution code, never below one.
    function automatic longint unsigned tick_cycles(longint unsigned clk_hz, int unsigned code);
        longint unsigned us;
        longint unsigned v;
        case (code)
            0:       us = 64'd32;
            1:       us = 64'd10_000;
            2:       us = 64'd100_000;
            default: us = 64'd1_000_000;
        endcase
        v = (clk_hz * us) / 64'd1_000_000;
        if (v == 0) v = 1;
        return v;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned DEF_COUNT = 60
) (
    input  logic              clk,
    input  logic              rst_any,
    input  logic              por_rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  remaining,
    input  logic              expire,
    output ctrl_t             ctrl_o,
    output cfg_t              cfg_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              fired_o,
    output logic              kick_load_o,
    output logic              res_change_o
);

    logic sel_ctrl, sel_cnt, sel_cfg;
    logic wr_ctrl, wr_cnt, wr_cfg;
    logic [CNT_W-1:0] wr_count_val;

    assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_cnt  = (bus_addr == ADDR_W'(OFS_COUNT));
    assign sel_cfg  = (bus_addr == ADDR_W'(OFS_CFG));

    assign wr_ctrl = bus_we && sel_ctrl && !rst_any;
    assign wr_cnt  = bus_we && sel_cnt  && !rst_any;
    assign wr_cfg  = bus_we && sel_cfg  && !rst_any;

    assign wr_count_val = (bus_wdata[CNT_W-1:0] == '0) ? CNT_W'(1) : bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst_any) begin
            ctrl_o   <= '{run_en: 1'b0, action: ACT_REBOOT};
            cfg_o    <= '{glob_en: 1'b0, res: RES_32US};
            reload_o <= CNT_W'(DEF_COUNT);
        end else begin
            if (wr_ctrl) begin
                ctrl_o.run_en <= bus_wdata[CTRL_RUN_BIT];
                ctrl_o.action <= act_e'(bus_wdata[CTRL_ACT_BIT]);
            end
            if (wr_cfg) begin
                cfg_o.glob_en <= bus_wdata[CFG_EN_BIT];
                cfg_o.res     <= res_e'(bus_wdata[1:0]);
            end
            if (wr_cnt) reload_o <= wr_count_val;
        end
    end

    // Sticky flag: only power-on reset or a write of one clears it; expiry wins.
    always_ff @(posedge clk) begin
        if (por_rst)                               fired_o <= 1'b0;
        else if (expire)                           fired_o <= 1'b1;
        else if (wr_ctrl && bus_wdata[CTRL_FIRED_BIT]) fired_o <= 1'b0;
    end

    assign kick_load_o  = wr_ctrl && bus_wdata[CTRL_KICK_BIT] && bus_wdata[CTRL_RUN_BIT]
                          && cfg_o.glob_en;
    assign res_change_o = wr_cfg && (bus_wdata[1:0] != cfg_o.res);

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[CTRL_RUN_BIT]   = ctrl_o.run_en;
            bus_rdata[CTRL_FIRED_BIT] = fired_o;
            bus_rdata[CTRL_ACT_BIT]   = ctrl_o.action;
        end else if (sel_cnt) begin
            bus_rdata[CNT_W-1:0] = remaining;
        end else if (sel_cfg) begin
            bus_rdata[CFG_EN_BIT] = cfg_o.glob_en;
            bus_rdata[1:0]        = cfg_o.res;
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_any,
    input  logic enable,
    input  logic restart,
    input  res_e res,
    output logic tick
);

    localparam int unsigned PSC_W = $clog2(CLK_HZ + 1);
    localparam int unsigned N_RES = 4;

    logic [PSC_W-1:0] div_tab [N_RES];
    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] psc_last;

    for (genvar g = 0; g < N_RES; g++) begin : g_div
        localparam longint unsigned CYC = tick_cycles(longint'(CLK_HZ), g);
        assign div_tab[g] = PSC_W'(CYC - 1);
    end

    assign psc_last = div_tab[res];
    assign tick     = enable && (psc_q == psc_last);

    always_ff @(posedge clk) begin
        if (rst_any || restart) psc_q <= '0;
        else if (enable)        psc_q <= tick ? '0 : psc_q + 1'b1;
    end

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_any,
    input  logic             run,
    input  logic             kick_load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] remaining,
    output logic             armed,
    output logic             expire
);

    logic at_one;
    assign at_one = (remaining == CNT_W'(1));
    assign expire = armed && run && tick && at_one && !kick_load && !rst_any;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            remaining <= '0;
            armed     <= 1'b0;
        end else if (kick_load) begin
            remaining <= load_val;
            armed     <= 1'b1;
        end else if (!run) begin
            armed <= 1'b0;
        end else if (armed && tick) begin
            remaining <= remaining - 1'b1;
            if (at_one) armed <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_resolution_timer.sv
module wdt_resolution_timer
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned DEF_COUNT = 60
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              reboot_req,
    output logic              shutdown_req
);

    logic             rst_any;
    ctrl_t            ctrl;
    cfg_t             cfg;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] remaining;
    logic             fired;
    logic             kick_load;
    logic             res_change;
    logic             run;
    logic             armed;
    logic             tick;
    logic             expire;

    assign rst_any = rst || por_rst;
    assign run     = ctrl.run_en && cfg.glob_en;

    wdt_regs #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .DEF_COUNT(DEF_COUNT)
    ) regs_i (
        .clk         (clk),
        .rst_any     (rst_any),
        .por_rst     (por_rst),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .remaining   (remaining),
        .expire      (expire),
        .ctrl_o      (ctrl),
        .cfg_o       (cfg),
        .reload_o    (reload_val),
        .fired_o     (fired),
        .kick_load_o (kick_load),
        .res_change_o(res_change)
    );

    wdt_prescaler #(
        .CLK_HZ(CLK_HZ)
    ) psc_i (
        .clk    (clk),
        .rst_any(rst_any),
        .enable (armed && run),
        .restart(kick_load || res_change),
        .res    (cfg.res),
        .tick   (tick)
    );

    wdt_downcount #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk      (clk),
        .rst_any  (rst_any),
        .run      (run),
        .kick_load(kick_load),
        .load_val (reload_val),
        .tick     (tick),
        .remaining(remaining),
        .armed    (armed),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst_any) begin
            reboot_req   <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            reboot_req   <= expire && (ctrl.action == ACT_REBOOT);
            shutdown_req <= expire && (ctrl.action == ACT_SHUTDOWN);
        end
    end

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              por_rst,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [CNT_W-1:0]  remaining,
    input logic              kick_load,
    input logic              run,
    input logic              fired,
    input logic              reboot_req,
    input logic              shutdown_req
);

    logic any_req;
    logic clear_try;
    assign any_req   = reboot_req || shutdown_req;
    assign clear_try = bus_we && (bus_addr == ADDR_W'(0)) && bus_wdata[1];

    assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (por_rst || rst)
        !(reboot_req && shutdown_req));

    assert_req_one_cycle_R5: assert property (@(posedge clk) disable iff (por_rst || rst)
        any_req |=> !any_req);

    assert_req_after_last_tick_R5: assert property (@(posedge clk) disable iff (por_rst || rst)
        any_req |-> (remaining == '0) && ($past(remaining) == CNT_W'(1)));

    assert_zero_holds_R5: assert property (@(posedge clk) disable iff (por_rst || rst)
        (remaining == '0 && !kick_load) |=> remaining == '0);

    assert_no_rise_without_kick_R4: assert property (@(posedge clk) disable iff (por_rst || rst)
        !kick_load |=> remaining <= $past(remaining));

    assert_req_sets_fired_R7: assert property (@(posedge clk) disable iff (por_rst || rst)
        any_req |-> fired);

    assert_fired_sticky_R8: assert property (@(posedge clk) disable iff (por_rst)
        (fired && !clear_try) |=> fired);

    assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (por_rst || rst)
        !run |=> !any_req);

endmodule

bind wdt_resolution_timer wdt_checker #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk         (clk),
    .por_rst     (por_rst),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .remaining   (remaining),
    .kick_load   (kick_load),
    .run         (run),
    .fired       (fired),
    .reboot_req  (reboot_req),
    .shutdown_req(shutdown_req)
);

// File: tb/wdt_resolution_timer_tb.sv
`timescale 1ns/1ps
module wdt_resolution_timer_tb_top;

    localparam int unsigned SIM_HZ = 100_000;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_CNT  = 4'h4;
    localparam logic [3:0] A_CFG  = 4'h8;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        reboot_req, shutdown_req;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    wdt_resolution_timer #(.CLK_HZ(SIM_HZ)) dut_i (
        .clk(clk), .por_rst(por_rst), .rst(rst), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reboot_req(reboot_req), .shutdown_req(shutdown_req)
    );

    function automatic int unsigned exp_div(int code);
        longint unsigned us;
        longint unsigned v;
        case (code)
            0: us = 32;
            1: us = 10_000;
            2: us = 100_000;
            default: us = 1_000_000;
        endcase
        v = (longint'(SIM_HZ) * us) / 1_000_000;
        if (v < 1) v = 1;
        return int'(v);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Trigger with the given timeout and action, then check the exact expiry cycle.
    task automatic kick_and_expect(int n, int d, bit act, string tag);
        logic [31:0] v;
        wr(A_CTRL, 32'h81 | (32'(act) << 2));
        repeat (n * d - 1) @(posedge clk);
        #1;
        chk({tag, " R5 no early request"}, {30'd0, reboot_req, shutdown_req}, 32'd0);
        rd(A_CNT, v); chk({tag, " R4 count one tick before end"}, v, 32'd1);
        @(posedge clk); #1;
        chk({tag, " R5 reboot pulse"},   {31'd0, reboot_req},   {31'd0, !act});
        chk({tag, " R5 shutdown pulse"}, {31'd0, shutdown_req}, {31'd0, act});
        rd(A_CNT, v);  chk({tag, " R5 count zero"}, v, 32'd0);
        rd(A_CTRL, v); chk({tag, " R7 fired set"}, v & 32'h2, 32'h2);
        @(posedge clk); #1;
        chk({tag, " R5 pulse one cycle"}, {30'd0, reboot_req, shutdown_req}, 32'd0);
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 por_rst = 1'b0; rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, v); chk("R1 control", v, 0);
        rd(A_CFG, v);  chk("R1 config", v, 0);
        rd(A_CNT, v);  chk("R1 remaining", v, 0);
        chk("R1 requests", {30'd0, reboot_req, shutdown_req}, 0);

        // R3 trigger with global enable off is ignored
        wr(A_CTRL, 32'h81);
        repeat (10) @(posedge clk); #1;
        rd(A_CNT, v); chk("R3 kick while disabled", v, 0);

        // R2 field layout, reserved bits
        wr(A_CFG, 32'hFFFF_FF7C);
        rd(A_CFG, v); chk("R2 config readback", v, 32'h0);
        wr(A_CFG, 32'h0000_00FC);
        rd(A_CFG, v); chk("R2 config enable only", v, 32'h80);
        wr(A_CTRL, 32'h0000_007D);
        rd(A_CTRL, v); chk("R2 control readback", v, 32'h05);

        // R3 start alone does not count
        repeat (40) @(posedge clk); #1;
        rd(A_CNT, v); chk("R3 start without kick", v, 0);
        wr(A_CTRL, 32'h80);
        repeat (10) @(posedge clk); #1;
        rd(A_CNT, v); chk("R3 kick with start clear", v, 0);

        // R10 zero clamp and 16-bit mask
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h81); #1;
        rd(A_CNT, v);  chk("R10 zero timeout stored as one", v, 1);
        rd(A_CTRL, v); chk("R2 trigger bit reads zero", v & 32'h80, 0);
        wr(A_CTRL, 32'h02);
        wr(A_CNT, 32'h0001_2345);
        wr(A_CTRL, 32'h81); #1;
        rd(A_CNT, v); chk("R10 low bits only", v, 32'h2345);
        wr(A_CTRL, 32'h02);

        // R4 R5 R7 random timeouts and actions at resolution 0
        for (int i = 0; i < 8; i++) begin
            int n;
            bit a;
            n = 1 + int'($urandom % 12);
            a = 1'($urandom % 2);
            wr(A_CTRL, 32'h02);
            wr(A_CNT, 32'(n));
            kick_and_expect(n, exp_div(0), a, "rnd");
            repeat (20) @(posedge clk); #1;
            rd(A_CNT, v); chk("R5 held at zero", v, 0);
            chk("R5 no repeat pulse", {30'd0, reboot_req, shutdown_req}, 0);
        end

        // R7 write-zero keeps flag, write-one clears
        wr(A_CTRL, 32'h01);
        rd(A_CTRL, v); chk("R7 write zero keeps fired", v & 32'h2, 32'h2);
        wr(A_CTRL, 32'h02);
        rd(A_CTRL, v); chk("R7 write one clears", v & 32'h2, 32'h0);

        // R4 resolution 1
        wr(A_CFG, 32'h81);
        wr(A_CNT, 32'd2);
        kick_and_expect(2, exp_div(1), 1'b1, "res1");

        // R6 keep-alive reload, R4 mid count
        wr(A_CFG, 32'h80);
        wr(A_CTRL, 32'h02);
        wr(A_CNT, 32'd10);
        wr(A_CTRL, 32'h81);
        repeat (12) @(posedge clk); #1;
        rd(A_CNT, v); chk("R4 mid count", v, 32'(10 - 12 / exp_div(0)));
        wr(A_CTRL, 32'h81); #1;
        rd(A_CNT, v); chk("R6 reload on keep-alive", v, 10);
        wr(A_CTRL, 32'h02);
        kick_and_expect(10, exp_div(0), 1'b0, "R6 keepalive");

        // R9 stop freezes
        wr(A_CTRL, 32'h02);
        wr(A_CTRL, 32'h81);
        repeat (7) @(posedge clk);
        wr(A_CTRL, 32'h00); #1;
        rd(A_CNT, v);
        repeat (60) @(posedge clk); #1;
        rd(A_CNT, v2); chk("R9 stop freezes count", v2, v);
        rd(A_CTRL, v2); chk("R9 no expiry after stop", v2 & 32'h2, 0);

        // R9 global enable off freezes; restart without kick stays frozen
        wr(A_CTRL, 32'h81);
        repeat (7) @(posedge clk);
        wr(A_CFG, 32'h00); #1;
        rd(A_CNT, v);
        repeat (60) @(posedge clk); #1;
        rd(A_CNT, v2); chk("R9 disable freezes count", v2, v);
        wr(A_CFG, 32'h80);
        repeat (60) @(posedge clk); #1;
        rd(A_CNT, v2); chk("R9 re-enable needs kick", v2, v);
        chk("R9 no request", {30'd0, reboot_req, shutdown_req}, 0);

        // R11 resolution change restarts phase
        wr(A_CTRL, 32'h02);
        wr(A_CFG, 32'h81);
        wr(A_CNT, 32'd5);
        wr(A_CTRL, 32'h81);
        repeat (500) @(posedge clk);
        wr(A_CFG, 32'h80);
        repeat (exp_div(0) - 1) @(posedge clk); #1;
        rd(A_CNT, v); chk("R11 no tick before new period", v, 5);
        @(posedge clk); #1;
        rd(A_CNT, v); chk("R11 first tick after new period", v, 4);
        wr(A_CTRL, 32'h02);

        // R4 resolutions 2 and 3
        wr(A_CFG, 32'h82);
        wr(A_CNT, 32'd1);
        kick_and_expect(1, exp_div(2), 1'b0, "res2");
        wr(A_CFG, 32'h83);
        kick_and_expect(1, exp_div(3), 1'b1, "res3");

        // R8 system reset keeps fired, power-on reset clears it
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk); #1 rst = 1'b0;
        rd(A_CTRL, v); chk("R8 fired survives rst", v, 32'h2);
        rd(A_CFG, v);  chk("R8 config cleared by rst", v, 0);
        @(negedge clk); por_rst = 1'b1;
        repeat (2) @(posedge clk); #1 por_rst = 1'b0;
        rd(A_CTRL, v); chk("R8 por clears fired", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule